// File: doc/BRIEF.md
# Programmable-Length SPI Master with Automatic Select

This block is a single-transfer SPI master driven through a small word-addressed register port. Software loads up to four 32-bit transmit words and picks a clock divider and a set of slave-select lines. It then writes the control word with the start bit set and polls the busy flag until the shift ends. The block shifts a character of 1 to 128 bits out on MOSI. It captures MISO into a separate receive buffer that software reads back from the same word addresses.

Each transfer can set the edge that launches MOSI and the edge that samples MISO independently. It can also set the bit order, and whether the chosen select lines are driven low by hardware for the length of the transfer or follow the mask register directly. An optional interrupt marks the end of a transfer.

The controller is a four-state machine. IDLE waits for a start. LEAD holds SCLK low for one half-period with the selects active. SHIFT produces the SCLK edges. TRAIL holds for one half-period after the last edge. The transitions are:
- IDLE to LEAD on an accepted start write.
- LEAD to SHIFT on the first half-period tick, which is also the first rising edge.
- SHIFT to TRAIL on the tick that makes the last falling edge.
- TRAIL to IDLE on the next tick.

Top module: `spi_xfer_master`

## Requirements
- R1: After reset, SCLK and MOSI are low, every select line and the interrupt are inactive (ss_n all ones, irq low), and every register reads zero.
- R2: Word index = reg_addr[4:2]. Indexes 0 to 3 write transmit words and read receive words. Index 4 is control: bits 6:0 length, bit 8 start/busy, bit 9 sample-on-falling, bit 10 launch-on-falling, bit 11 LSB-first, bit 12 interrupt enable, bit 13 automatic select; control reads back bits 13:9 and 6:0. Index 5 is the divider, keeping bits 15:0. Index 6 is the select mask, keeping bits 6:0.
- R3: A control write with bit 8 set while idle starts a transfer. Busy (control bit 8) reads 1 from the next cycle for exactly H*(2L+1) cycles, where H = 2*(divider+1) and L is the length.
- R4: SCLK is low when idle. Its first rising edge comes H cycles after the start. It then toggles every H cycles for exactly 2L edges, and the last edge is falling.
- R5: MOSI carries transfer bit 0 from the cycle after the start. At the k-th launch edge (counted from 0), it moves to bit k+1, and it stays on bit L-1 after that. Launch edges are rising when control bit 10 is 0 and falling when it is 1. MOSI returns low when the transfer ends.
- R6: Transfer bit j is sampled from MISO on the rising edge of bit j when control bit 9 is 0, and on its falling edge when bit 9 is 1. Receive bits at positions L and above keep their previous value.
- R7: Transfer bit j maps to buffer position L-1-j when MSB-first (bit 11 = 0) and to position j when LSB-first. Buffer position p is bit p mod 32 of word p/32, so byte i of an LSB-first transfer sits at bits 8*(i mod 4) upward of word i/4.
- R8: A length field of 0 gives a 128-bit transfer.
- R9: With control bit 13 set, ss_n is low exactly on the mask bits while busy and all ones otherwise. With bit 13 clear, ss_n is the inverse of the mask at all times.
- R10: Every register write made while busy is ignored, including a second start.
- R11: With control bit 12 set, irq rises in the cycle busy falls. It stays high until a register read or write, and is low in the cycle after that access. With bit 12 clear, irq stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the interrupt) |
| reg_addr | input | 5 | Byte address; bits 4:2 select the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 7 | Active-low slave selects |
| irq | output | 1 | End-of-transfer interrupt |

## Verification
A wrong half-period count or edge counter shows at SCLK at the next expected edge, no more than H cycles late. A wrong state shows at once on the busy bit and, with automatic select, on ss_n. A bad bit index or order selection shows on MOSI at the next launch edge. A bad receive position stays hidden until the words are read after the transfer, so every transfer ends with a read of all four words against a bit-by-bit model.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL
    } xfer_state_t;

    // Field order matches control bits 13:9
    typedef struct packed {
        logic auto_ss;
        logic irq_en;
        logic lsb_first;
        logic tx_fall;
        logic rx_fall;
    } xfer_flags_t;

    localparam int XFER_FLAGS_W   = 5;
    localparam int CTRL_GO_BIT    = 8;
    localparam int CTRL_FLAGS_LSB = 9;
    localparam int WORD_W         = 32;

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;

    // half-period of 2*(div+1) cycles: count reload..0
    assign reload = {div, 1'b1};
    assign tick   = run && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= reload;
        end else if (run) begin
            cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/spi_bit_locator.sv
module spi_bit_locator #(
    parameter int LEN_W = 7
) (
    input  logic [LEN_W-1:0] len_code,
    input  logic             lsb_first,
    input  logic [LEN_W:0]   order_idx,
    output logic [LEN_W:0]   xfer_len,
    output logic [LEN_W-1:0] bit_pos
);
    localparam logic [LEN_W:0] FULL_LEN = (LEN_W+1)'(1) << LEN_W;

    logic [LEN_W:0] span_left;
    logic           unused_msb;

    always_comb begin
        xfer_len  = (len_code == '0) ? FULL_LEN : {1'b0, len_code};
        span_left = xfer_len - (LEN_W+1)'(1) - order_idx;
        bit_pos   = lsb_first ? order_idx[LEN_W-1:0] : span_left[LEN_W-1:0];
    end

    assign unused_msb = span_left[LEN_W];
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master #(
    parameter int WORDS  = 4,
    parameter int NUM_SS = 7,
    parameter int DIV_W  = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_SS-1:0] ss_n,
    output logic              irq
);
    import spi_xfer_pkg::*;

    localparam int BUF_W  = WORDS * WORD_W;
    localparam int LEN_W  = $clog2(BUF_W);
    localparam int ECNT_W = LEN_W + 2;
    localparam int SEL_W  = ADDR_W - 2;
    localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(WORDS);
    localparam logic [SEL_W-1:0] SEL_DIV  = SEL_W'(WORDS + 1);
    localparam logic [SEL_W-1:0] SEL_SS   = SEL_W'(WORDS + 2);

    xfer_state_t        state, state_nx;
    xfer_flags_t        flags_q, new_flags;
    logic [LEN_W-1:0]   len_q;
    logic [DIV_W-1:0]   div_q;
    logic [NUM_SS-1:0]  ss_q;
    logic [BUF_W-1:0]   tx_flat, rx_flat;
    logic [ECNT_W-1:0]  edge_cnt;
    logic               sclk_q, mosi_q, irq_q;

    logic [SEL_W-1:0]   word_sel;
    logic               wr_ok, go, busy, sel_live, auto_sel;
    logic               tick, edge_tick, rising, sample_now, drive_now, last_edge;
    logic [LEN_W:0]     bit_j, next_j, tx_order;
    logic [LEN_W:0]     rx_len, tx_len;
    logic [LEN_W-1:0]   rx_pos, tx_pos, tx_len_code;
    logic               tx_lsb, tx_bit;
    logic [1:0]         unused_addr;

    assign word_sel    = reg_addr[ADDR_W-1:2];
    assign unused_addr = reg_addr[1:0];
    assign wr_ok       = reg_wr && (state == ST_IDLE);
    assign go          = wr_ok && (word_sel == SEL_CTRL) && reg_wdata[CTRL_GO_BIT];
    assign new_flags   = xfer_flags_t'(reg_wdata[CTRL_FLAGS_LSB +: XFER_FLAGS_W]);
    assign auto_sel    = flags_q.auto_ss;

    // transmit words, one register per word
    for (genvar gw = 0; gw < WORDS; gw++) begin : g_txw
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_ok && (word_sel == SEL_W'(gw))) begin
                word_q <= reg_wdata;
            end
        end
        assign tx_flat[gw*WORD_W +: WORD_W] = word_q;
    end

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            len_q   <= '0;
            div_q   <= '0;
            ss_q    <= '0;
        end else if (wr_ok) begin
            if (word_sel == SEL_CTRL) begin
                flags_q <= new_flags;
                len_q   <= reg_wdata[LEN_W-1:0];
            end
            if (word_sel == SEL_DIV) div_q <= reg_wdata[DIV_W-1:0];
            if (word_sel == SEL_SS)  ss_q  <= reg_wdata[NUM_SS-1:0];
        end
    end

    spi_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (go),
        .run   (busy),
        .div   (div_q),
        .tick  (tick)
    );

    // edge bookkeeping
    assign rising     = ~edge_cnt[0];
    assign bit_j      = edge_cnt[ECNT_W-1:1];
    assign next_j     = bit_j + 1'b1;
    assign sample_now = rising ^ flags_q.rx_fall;
    assign drive_now  = rising ^ flags_q.tx_fall;
    assign edge_tick  = tick && ((state == ST_LEAD) || (state == ST_SHIFT));
    assign last_edge  = (edge_cnt == ({rx_len, 1'b0} - ECNT_W'(1)));

    spi_bit_locator #(.LEN_W(LEN_W)) u_rx_loc (
        .len_code  (len_q),
        .lsb_first (flags_q.lsb_first),
        .order_idx (bit_j),
        .xfer_len  (rx_len),
        .bit_pos   (rx_pos)
    );

    // at the start the new control word decides bit 0
    assign tx_len_code = (state == ST_IDLE) ? reg_wdata[LEN_W-1:0] : len_q;
    assign tx_lsb      = (state == ST_IDLE) ? new_flags.lsb_first : flags_q.lsb_first;
    assign tx_order    = (state == ST_IDLE) ? '0 : next_j;

    spi_bit_locator #(.LEN_W(LEN_W)) u_tx_loc (
        .len_code  (tx_len_code),
        .lsb_first (tx_lsb),
        .order_idx (tx_order),
        .xfer_len  (tx_len),
        .bit_pos   (tx_pos)
    );

    assign tx_bit = tx_flat[tx_pos];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (go)                     state_nx = ST_LEAD;
            ST_LEAD:  if (tick)                   state_nx = ST_SHIFT;
            ST_SHIFT: if (tick && last_edge)      state_nx = ST_TRAIL;
            ST_TRAIL: if (tick)                   state_nx = ST_IDLE;
            default:                              state_nx = ST_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        unique case (state)
            ST_IDLE: begin busy = 1'b0; sel_live = 1'b0; end
            default: begin busy = 1'b1; sel_live = 1'b1; end
        endcase
    end

    assign ss_n = ~(ss_q & {NUM_SS{!auto_sel || sel_live}});

    // serial datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt <= '0;
            sclk_q   <= 1'b0;
            mosi_q   <= 1'b0;
            rx_flat  <= '0;
        end else if (go) begin
            edge_cnt <= '0;
            sclk_q   <= 1'b0;
            mosi_q   <= tx_bit;
        end else if (edge_tick) begin
            sclk_q   <= ~sclk_q;
            edge_cnt <= edge_cnt + 1'b1;
            if (sample_now) rx_flat[rx_pos] <= miso;
            if (drive_now && (next_j < rx_len)) mosi_q <= tx_bit;
        end else if (tick && (state == ST_TRAIL)) begin
            mosi_q <= 1'b0;
        end
    end

    // interrupt: set wins over an access in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (tick && (state == ST_TRAIL) && flags_q.irq_en) begin
            irq_q <= 1'b1;
        end else if (reg_wr || reg_rd) begin
            irq_q <= 1'b0;
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (word_sel < SEL_CTRL) begin
            reg_rdata = rx_flat[word_sel[SEL_W-2:0]*WORD_W +: WORD_W];
        end else if (word_sel == SEL_CTRL) begin
            reg_rdata[CTRL_FLAGS_LSB +: XFER_FLAGS_W] = flags_q;
            reg_rdata[CTRL_GO_BIT]                    = busy;
            reg_rdata[LEN_W-1:0]                      = len_q;
        end else if (word_sel == SEL_DIV) begin
            reg_rdata[DIV_W-1:0] = div_q;
        end else if (word_sel == SEL_SS) begin
            reg_rdata[NUM_SS-1:0] = ss_q;
        end
    end

    assign sclk = sclk_q;
    assign mosi = mosi_q;
    assign irq  = irq_q;

endmodule

// File: rtl/spi_xfer_checker.sv
module spi_xfer_checker #(
    parameter int NUM_SS = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              sclk,
    input logic              mosi,
    input logic [NUM_SS-1:0] ss_n,
    input logic              irq,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic              auto_sel,
    input logic [NUM_SS-1:0] ss_mask
);
    // R4
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    // R5
    mosi_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mosi);

    // R9
    auto_sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && auto_sel) |-> (&ss_n));

    // R10
    mask_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ss_mask));

    // R11
    irq_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $fell(busy));

    // R11
    irq_access_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_wr || reg_rd) && !busy) |=> !irq);
endmodule

bind spi_xfer_master spi_xfer_checker #(.NUM_SS(NUM_SS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .sclk     (sclk),
    .mosi     (mosi),
    .ss_n     (ss_n),
    .irq      (irq),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .auto_sel (auto_sel),
    .ss_mask  (ss_q)
);

// File: tb/spi_xfer_master_test.sv
module spi_xfer_master_test;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, miso = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk, mosi, irq;
    logic [6:0]  ss_n;

    always #5 clk = ~clk;

    spi_xfer_master uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n), .irq(irq)
    );

    int n_run = 0, n_bad = 0;
    logic [127:0] tx_model = '0, rx_model = '0;
    int     bad[5];
    longint fa[5], fe[5];
    string  tag[5]  = '{"R4", "R5", "R9", "R3", "R11"};
    string  what[5] = '{"sclk", "mosi", "ss_n", "busy", "irq"};

    task automatic check(input bit ok, input string req, input string nm,
                         input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, nm, act, exp);
        end
    endtask

    task automatic note(input int k, input longint act, input longint exp);
        if (act != exp) begin
            if (bad[k] == 0) begin fa[k] = act; fe[k] = exp; end
            bad[k]++;
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); #1 reg_rd = 1'b0;
    endtask

    function automatic int posf(input int j, input int len, input bit lsb);
        return lsb ? j : len - 1 - j;
    endfunction

    task automatic run_xfer(input int lcode, input int div, input bit rxf, input bit txf,
                            input bit lsb, input bit ie, input bit aut, input logic [6:0] mask,
                            input bit load_tx, input logic [127:0] txv,
                            input logic [127:0] pat, input bit mid_write);
        int len, hp, cend, ed, dd, idx;
        bit busy_e, sclk_e, mosi_e;
        logic [6:0] ss_e;
        logic [31:0] d, ctrl;
        len = (lcode == 0) ? 128 : lcode;
        hp = 2 * (div + 1);
        cend = hp * (2 * len + 1);
        if (load_tx) begin
            for (int w = 0; w < 4; w++) wr(5'(w * 4), txv[w*32 +: 32]);
            tx_model = txv;
        end
        wr(5'h14, 32'(div));
        wr(5'h18, {25'd0, mask});
        ctrl = (32'(aut) << 13) | (32'(ie) << 12) | (32'(lsb) << 11) |
               (32'(txf) << 10) | (32'(rxf) << 9) | 32'h100 | 32'(lcode);
        for (int k = 0; k < 5; k++) bad[k] = 0;
        @(negedge clk); reg_wr = 1'b1; reg_addr = 5'h10; reg_wdata = ctrl;
        @(posedge clk);
        for (int c = 0; c <= cend; c++) begin
            @(negedge clk);
            reg_wr = 1'b0; reg_rd = 1'b0;
            ed = c / hp; if (ed > 2 * len) ed = 2 * len;
            busy_e = (c < cend);
            sclk_e = busy_e && (ed % 2 == 1);
            dd = txf ? ed / 2 : (ed + 1) / 2;
            idx = (dd > len - 1) ? len - 1 : dd;
            mosi_e = busy_e ? tx_model[posf(idx, len, lsb)] : 1'b0;
            ss_e = aut ? (busy_e ? ~mask : 7'h7f) : ~mask;
            miso = pat[((ed >= 2 * len) ? 2 * len - 1 : ed) / 2];
            note(0, longint'(sclk), longint'(sclk_e));
            note(1, longint'(mosi), longint'(mosi_e));
            note(2, longint'(ss_n), longint'(ss_e));
            note(4, longint'(irq), longint'(busy_e ? 1'b0 : ie));
            if (busy_e) begin
                if (mid_write && c >= 3 * hp && c < 3 * hp + 4) begin
                    // R10: writes issued while busy
                    reg_wr = 1'b1;
                    case (c - 3 * hp)
                        0: begin reg_addr = 5'h14; reg_wdata = 32'h7; end
                        1: begin reg_addr = 5'h18; reg_wdata = 32'h10; end
                        2: begin reg_addr = 5'h00; reg_wdata = 32'hFFFF_FFFF; end
                        default: begin reg_addr = 5'h10; reg_wdata = 32'h0000_2101; end
                    endcase
                end else begin
                    reg_rd = 1'b1; reg_addr = 5'h10;
                    #1 note(3, longint'(reg_rdata[8]), 64'd1);
                end
            end
        end
        for (int k = 0; k < 5; k++) check(bad[k] == 0, tag[k], what[k], fa[k], fe[k]);
        // R11: flag holds with no access, then one access clears it
        @(negedge clk);
        check(irq == ie, "R11", "irq held", longint'(irq), longint'(ie));
        reg_rd = 1'b1; reg_addr = 5'h10;
        #1 check(reg_rdata[8] == 1'b0, "R3", "busy after end", longint'(reg_rdata[8]), 0);
        @(posedge clk); #1 reg_rd = 1'b0;
        @(negedge clk);
        check(irq == 1'b0, "R11", "irq cleared", longint'(irq), 0);
        // R6 R7 R8: receive words
        for (int j = 0; j < len; j++) rx_model[posf(j, len, lsb)] = pat[j];
        for (int w = 0; w < 4; w++) begin
            rd(5'(w * 4), d);
            check(d == rx_model[w*32 +: 32], "R7", "rx word", longint'(d),
                  longint'(rx_model[w*32 +: 32]));
        end
        if (mid_write) begin
            rd(5'h14, d); check(d == 32'(div), "R10", "divider", longint'(d), longint'(div));
            rd(5'h18, d); check(d[6:0] == mask, "R10", "mask", longint'(d), longint'(mask));
        end
    endtask

    initial begin
        #(200000 * 10);
        n_run++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(sclk == 1'b0 && mosi == 1'b0, "R1", "sclk/mosi", longint'({sclk, mosi}), 0);
        check(ss_n == 7'h7f, "R1", "ss_n", longint'(ss_n), 64'h7f);
        check(irq == 1'b0, "R1", "irq", longint'(irq), 0);
        rd(5'h10, d); check(d == 0, "R1", "ctrl", longint'(d), 0);
        rd(5'h04, d); check(d == 0, "R1", "rx word1", longint'(d), 0);
        // R2
        wr(5'h14, 32'h0001_2345);
        rd(5'h14, d); check(d == 32'h2345, "R2", "divider width", longint'(d), 64'h2345);
        wr(5'h18, 32'hFF);
        rd(5'h18, d); check(d == 32'h7F, "R2", "mask width", longint'(d), 64'h7f);
        wr(5'h10, 32'hFFFF_FEFF);
        rd(5'h10, d); check(d == 32'h3E7F, "R2", "ctrl fields", longint'(d), 64'h3e7f);
        // R9: automatic select on, idle
        @(negedge clk);
        check(ss_n == 7'h7f, "R9", "auto idle ss_n", longint'(ss_n), 64'h7f);
        wr(5'h10, 32'h0);
        @(negedge clk);
        check(ss_n == 7'h00, "R9", "manual ss_n", longint'(ss_n), 0);

        // R4 R5 R6: MSB-first, rising edges, auto select
        run_xfer(8, 0, 0, 0, 0, 0, 1, 7'h01, 1,
                 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32A5,
                 128'h0000_0000_0000_0000_0000_0000_0000_00C3, 0);
        // R7 R10 R11: LSB-first, falling edges, interrupt, writes while busy
        run_xfer(13, 1, 1, 1, 1, 1, 1, 7'h04, 1,
                 128'hDEAD_BEEF_0F1E_2D3C_4B5A_6978_8796_A5B4,
                 128'h0000_0000_0000_0000_0000_0000_0000_1A6D, 1);
        // R8: length 0, manual select, old transmit words kept (R10)
        run_xfer(0, 0, 0, 1, 0, 0, 0, 7'h40, 0, '0,
                 128'h9E37_79B9_7F4A_7C15_F39C_C060_5CED_C834, 0);
        // R7: 40 bits LSB-first, byte placement
        run_xfer(40, 2, 1, 0, 1, 1, 1, 7'h08, 1,
                 128'h5555_AAAA_3333_CCCC_0F0F_F0F0_1234_5678,
                 128'h0000_0000_0000_0000_0000_00B7_61D2_4E09, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule